// File: doc/BRIEF.md
# SPI FIFO Threshold and Word-Count Controller

This block sits beside the shared transmit/receive buffer of one SPI channel. It turns the buffer's fill level into two request lines for DMA or interrupt service. The receive request compares the current occupancy with a programmable threshold. The transmit request compares the free space with a second programmable threshold. Each threshold is programmed as its byte count minus one.

The block also tracks a programmed transfer length in SPI words. The shifter sends one strobe per finished word, and the block advances a live index on each strobe. When the index reaches the programmed length, the block emits a single-cycle completion pulse and holds the transmit request off until software reprograms the register. A length of zero turns counting off, so the transfer has no bound.

One 32-bit register holds all three fields and is written in a single access. Reading it back shows the live index in place of the programmed length once words have started to move. The shifter, the chip-select logic and the buffer storage are outside this block. They report their state through the fill-level, enable and strobe inputs.

Top module: `spi_fifo_thresh_ctrl`

## Requirements
- R1: After reset, all three register fields are zero, the readback is 0, and `xfer_done_o` is low.
- R2: Register layout: transfer length in bits 31:16, receive level in bits 13:8, transmit level in bits 5:0. Bits 15:14 and 7:6 read as 0 and ignore writes.
- R3: `rx_req_o` is high exactly when `rx_en_i` is high and `fill_lvl_i` is at least the receive level plus 1. It follows `fill_lvl_i` in the same cycle.
- R4: `tx_req_o` is high exactly when `tx_en_i` is high, the block is not halted (R7), and the free space (64 minus `fill_lvl_i`) is at least the transmit level plus 1. It follows `fill_lvl_i` in the same cycle.
- R5: After a register write, bits 31:16 read back the programmed length. Once the first counted word strobe after that write has occurred, they read back the live word index instead.
- R6: With a non-zero length, each `word_done_i` sampled high increments the index by 1. At the clock edge where the index reaches the length, `xfer_done_o` goes high for exactly one cycle. Strobes after that point leave the index unchanged.
- R7: After completion, `tx_req_o` stays low until the register is written again. `rx_req_o` is unaffected.
- R8: With a length of zero, strobes change nothing: the readback stays 0 and `xfer_done_o` never rises.
- R9: A new level value changes the request outputs only from the clock edge that captures the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register readback |
| fill_lvl_i | input | 7 | Buffer occupancy in bytes, 0 to 64 |
| rx_en_i | input | 1 | Receive operation active |
| tx_en_i | input | 1 | Transmit operation active |
| word_done_i | input | 1 | One SPI word finished |
| rx_req_o | output | 1 | Receive service request (level) |
| tx_req_o | output | 1 | Transmit service request (level) |
| xfer_done_o | output | 1 | Single-cycle end-of-transfer pulse |

## Verification
The assertions check the following on every cycle:
- the completion pulse lasts exactly one cycle;
- the index never passes a non-zero length;
- each counted strobe advances the index by exactly one;
- a zero length freezes the index;
- the transmit request stays low while the block is halted.

The threshold arithmetic, the n−1 encoding and the use of free space for transmit are checked only by the bench's scenarios. So are the swap of the readback field from length to index, the masking of reserved bits, and the one-clock delay before a new level takes effect.

// File: rtl/spi_ftc_pkg.sv
package spi_ftc_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 16;
  localparam int LVL_W   = 6;
  localparam int CNT_LSB = 16;
  localparam int RXL_LSB = 8;
  localparam int TXL_LSB = 0;

  typedef struct packed {
    logic [CNT_W-1:0] xfer_len;
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_lvl;
  } ftc_cfg_t;
endpackage

// File: rtl/ftc_regs.sv
module ftc_regs
  import spi_ftc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             started_i,
  output ftc_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  ftc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.xfer_len <= wdata_i[CNT_LSB +: CNT_W];
      cfg_q.rx_lvl   <= wdata_i[RXL_LSB +: LVL_W];
      cfg_q.tx_lvl   <= wdata_i[TXL_LSB +: LVL_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[CNT_LSB +: CNT_W] = started_i ? idx_i : cfg_q.xfer_len;
    rdata_o[RXL_LSB +: LVL_W] = cfg_q.rx_lvl;
    rdata_o[TXL_LSB +: LVL_W] = cfg_q.tx_lvl;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ftc_thresh.sv
module ftc_thresh #(
  parameter int DEPTH   = 64,
  parameter int LVL_W   = 6,
  parameter bit USE_FREE = 1'b0,
  localparam int FW     = $clog2(DEPTH + 1)
) (
  input  logic [FW-1:0]    fill_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             en_i,
  output logic             req_o
);
  logic [FW-1:0] thr, metric;

  // programmed value is n-1
  assign thr = FW'(lvl_i) + FW'(1);

  generate
    if (USE_FREE) begin : g_free
      assign metric = (fill_i >= FW'(DEPTH)) ? '0 : FW'(DEPTH) - fill_i;
    end else begin : g_occ
      assign metric = fill_i;
    end
  endgenerate

  assign req_o = en_i && (metric >= thr);
endmodule

// File: rtl/ftc_word_cnt.sv
module ftc_word_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             started_o,
  output logic             halt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] idx_q, idx_nxt;
  logic             started_q, halt_q, done_q, step;

  assign idx_nxt = idx_q + CNT_W'(1);
  assign step    = strobe_i && (len_i != '0) && !halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; started_q <= 1'b0; halt_q <= 1'b0; done_q <= 1'b0;
    end else if (clr_i) begin
      idx_q <= '0; started_q <= 1'b0; halt_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step) begin
        idx_q     <= idx_nxt;
        started_q <= 1'b1;
        if (idx_nxt == len_i) begin
          halt_q <= 1'b1;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign idx_o     = idx_q;
  assign started_o = started_q;
  assign halt_o    = halt_q;
  assign done_o    = done_q;

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_idx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i != '0) |-> (idx_q <= len_i));
  p_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && len_i != '0 && !halt_q && !clr_i) |=> (idx_q == $past(idx_q) + CNT_W'(1)));
  p_zero_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i == '0 && !clr_i) |=> $stable(idx_q));
endmodule

// File: rtl/spi_fifo_thresh_ctrl.sv
module spi_fifo_thresh_ctrl
  import spi_ftc_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_we_i,
  input  logic [31:0]                  reg_wdata_i,
  output logic [31:0]                  reg_rdata_o,
  input  logic [$clog2(DEPTH+1)-1:0]   fill_lvl_i,
  input  logic                         rx_en_i,
  input  logic                         tx_en_i,
  input  logic                         word_done_i,
  output logic                         rx_req_o,
  output logic                         tx_req_o,
  output logic                         xfer_done_o
);
  ftc_cfg_t         cfg;
  logic [CNT_W-1:0] idx;
  logic             started, halt, tx_raw;

  ftc_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .idx_i(idx), .started_i(started),
    .cfg_o(cfg), .rdata_o(reg_rdata_o)
  );

  ftc_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(reg_we_i), .len_i(cfg.xfer_len), .strobe_i(word_done_i),
    .idx_o(idx), .started_o(started), .halt_o(halt), .done_o(xfer_done_o)
  );

  ftc_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .USE_FREE(1'b0)) u_rx_thr (
    .fill_i(fill_lvl_i), .lvl_i(cfg.rx_lvl), .en_i(rx_en_i), .req_o(rx_req_o)
  );

  ftc_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .USE_FREE(1'b1)) u_tx_thr (
    .fill_i(fill_lvl_i), .lvl_i(cfg.tx_lvl), .en_i(tx_en_i), .req_o(tx_raw)
  );

  assign tx_req_o = tx_raw && !halt;

  p_tx_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> !tx_req_o);
  p_done_has_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> halt);
endmodule

// File: tb/spi_fifo_thresh_ctrl_tb.sv
module spi_fifo_thresh_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, rx_en = 1'b0, tx_en = 1'b0, wd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [6:0]  fill = '0;
  logic        rx_req, tx_req, done;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  spi_fifo_thresh_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fill_lvl_i(fill), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .word_done_i(wd), .rx_req_o(rx_req), .tx_req_o(tx_req), .xfer_done_o(done)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] len, input logic [5:0] rxl, input logic [5:0] txl);
    @(negedge clk);
    we = 1'b1; wdata = {len, 2'b00, rxl, 2'b00, txl};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); wd = 1'b1;
    @(negedge clk); wd = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(rdata, 32'h0, "R1 readback");
    chk({31'b0, done}, 32'h0, "R1 done");
    chk({31'b0, rx_req}, 32'h0, "R1 rx_req");
  endtask

  task automatic t_layout();
    @(negedge clk); we = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk); we = 1'b0;
    chk(rdata, 32'hFFFF_3F3F, "R2 reserved masked");
    wr(16'h1234, 6'h15, 6'h2A);
    chk(rdata, 32'h1234_152A, "R2 field positions");
  endtask

  task automatic t_rx();
    wr(16'd0, 6'd9, 6'd0);
    rx_en = 1'b1;
    fill = 7'd9;  #1; chk({31'b0, rx_req}, 32'd0, "R3 below thr");
    fill = 7'd10; #1; chk({31'b0, rx_req}, 32'd1, "R3 at thr");
    fill = 7'd64; #1; chk({31'b0, rx_req}, 32'd1, "R3 full");
    rx_en = 1'b0; #1; chk({31'b0, rx_req}, 32'd0, "R3 disabled");
    rx_en = 1'b1;
    wr(16'd0, 6'd0, 6'd0);
    fill = 7'd0; #1; chk({31'b0, rx_req}, 32'd0, "R3 lvl0 empty");
    fill = 7'd1; #1; chk({31'b0, rx_req}, 32'd1, "R3 lvl0 one byte");
    wr(16'd0, 6'd63, 6'd0);
    fill = 7'd63; #1; chk({31'b0, rx_req}, 32'd0, "R3 lvl63 at 63");
    fill = 7'd64; #1; chk({31'b0, rx_req}, 32'd1, "R3 lvl63 at 64");
    rx_en = 1'b0;
  endtask

  task automatic t_tx();
    wr(16'd0, 6'd0, 6'd3);
    tx_en = 1'b1;
    fill = 7'd60; #1; chk({31'b0, tx_req}, 32'd1, "R4 free 4");
    fill = 7'd61; #1; chk({31'b0, tx_req}, 32'd0, "R4 free 3");
    wr(16'd0, 6'd0, 6'd63);
    fill = 7'd0; #1; chk({31'b0, tx_req}, 32'd1, "R4 lvl63 empty");
    fill = 7'd1; #1; chk({31'b0, tx_req}, 32'd0, "R4 lvl63 one used");
    tx_en = 1'b0; fill = 7'd0; #1; chk({31'b0, tx_req}, 32'd0, "R4 disabled");
  endtask

  task automatic t_level_timing();
    wr(16'd0, 6'd9, 6'd0);
    rx_en = 1'b1; fill = 7'd15;
    @(negedge clk); we = 1'b1; wdata = {16'd0, 2'b00, 6'd20, 8'd0};
    #1; chk({31'b0, rx_req}, 32'd1, "R9 old level before edge");
    @(negedge clk); we = 1'b0;
    chk({31'b0, rx_req}, 32'd0, "R9 new level after edge");
    rx_en = 1'b0;
  endtask

  task automatic t_count();
    wr(16'd3, 6'd0, 6'd0);
    tx_en = 1'b1; rx_en = 1'b1; fill = 7'd1;
    chk(rdata[31:16], 32'd3, "R5 programmed readback");
    strobe(); chk(rdata[31:16], 32'd1, "R5 live index 1");
    chk({31'b0, done}, 32'd0, "R6 no done early");
    strobe(); chk(rdata[31:16], 32'd2, "R6 index 2");
    @(negedge clk); wd = 1'b1;
    @(negedge clk); wd = 1'b0;
    chk({31'b0, done}, 32'd1, "R6 done pulse");
    chk(rdata[31:16], 32'd3, "R6 index at length");
    chk({31'b0, tx_req}, 32'd0, "R7 tx held off");
    chk({31'b0, rx_req}, 32'd1, "R7 rx unaffected");
    @(negedge clk);
    chk({31'b0, done}, 32'd0, "R6 pulse one cycle");
    strobe(); chk(rdata[31:16], 32'd3, "R6 extra strobe ignored");
    chk({31'b0, done}, 32'd0, "R6 no second pulse");
    chk({31'b0, tx_req}, 32'd0, "R7 still held");
    wr(16'd2, 6'd0, 6'd0);
    chk({31'b0, tx_req}, 32'd1, "R7 released by write");
    chk(rdata[31:16], 32'd2, "R5 rewrite shows length");
    tx_en = 1'b0; rx_en = 1'b0;
  endtask

  task automatic t_zero();
    int seen = 0;
    wr(16'd0, 6'd0, 6'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); wd = 1'b1;
      @(negedge clk); wd = 1'b0;
      if (done) seen++;
    end
    chk(rdata[31:16], 32'd0, "R8 index unused");
    chk(seen, 32'd0, "R8 no done");
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    t_reset();
    t_layout();
    t_rx();
    t_tx();
    t_level_timing();
    t_count();
    t_zero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule